// File: doc/BRIEF.md
# Serial Channel Command and Interrupt Core

This block sits inside one channel of a serial communications controller and turns command codes written by the processor into actions on the transmitter, the receive queue and the interrupt logic. A three-bit command field inside each control write is decoded. The decoded command can send an abort, re-arm first-character receive interrupts, quiet the transmit interrupt, clear receive errors and release a held special-condition character, release the external/status latch, or retire the highest interrupt under service.

The core keeps one pending flag for each of three interrupt sources (receive/special, transmit, external/status) and one in-service bit per source. It raises a single interrupt request when an enabled pending source outranks every source already in service. An acknowledge input moves the winning source into service. The serializer, CRC engine, receive FIFO storage and bus interface lie outside. They talk to the core through level and pulse ports.

Top module: `sio_cmd_irq`

## Requirements
- R1: While reset is active and on the first cycle after it, irq, abort_send, err_clr, rx_hold and rx_discard are 0, pending and in_service are 000, and ext_latched is all zeros.
- R2: The command code sits in wr_data bits 5:3 and is acted on at the clock edge where wr_en is high. Codes 000 and 001 do nothing, and the other data bits are never decoded.
- R3: Code 011 produces a one-cycle abort_send pulse in the cycle after the write. This pulse tells the transmitter to emit 8 to 13 ones, empty its buffer and flag end of message.
- R4: Transmit pending (pending bit 1) sets on a 0-to-1 change of tx_buf_empty while tx_ie is 1. It clears on code 101 or on tx_load. After code 101, further empty transitions are ignored until tx_load or crc_done.
- R5: With rx_mode 01 (first character), the core starts armed, and the first character pushed, or already stored (rx_avail), sets receive pending (bit 2) and disarms. Later characters are ignored until code 100 re-arms the core. A character already stored then raises pending one cycle after the re-arm.
- R6: With rx_mode 10, every rx_push sets receive pending. With rx_mode 00, receive pending never sets.
- R7: A new special condition at the FIFO head (rx_avail and rx_special going high) sets receive pending in any mode other than 00. In modes 01 and 11 it also raises rx_hold. Code 110 pulses err_clr for one cycle and drops rx_hold. It pulses rx_discard in the same cycle only if the held character is still at the head.
- R8: While ext_latched is released, it follows ext_in. A change with ext_ie set captures the new value, sets external pending (bit 0) and freezes ext_latched. Code 010 releases the latch. An input that still differs from the latched value afterwards raises pending again. An input that has returned to the latched value raises nothing.
- R9: Priority is receive, then transmit, then external. irq is high when some source is pending, is enabled (rx_mode not 00, tx_ie, ext_ie), and ranks above every set in_service bit.
- R10: int_ack while irq is high sets the in_service bit of the highest requesting source and clears receive pending if that source was receive. Transmit and external pending are left as they are. int_ack while irq is low does nothing.
- R11: Code 111 clears only the highest-priority set in_service bit.
- R12: When a command and a status event land on the same edge, the event wins. A buffer-empty transition together with code 101 leaves transmit pending set, and a status change together with code 010 leaves external pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control write data; command field at bits 5:3 |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_mode | input | 2 | Receive interrupt mode: 00 off, 01 first char, 10 every char, 11 special only |
| ext_ie | input | 1 | External/status interrupt enable |
| tx_buf_empty | input | 1 | Transmit buffer empty level |
| tx_load | input | 1 | Pulse: character loaded into transmit buffer |
| crc_done | input | 1 | Pulse: CRC transmission finished |
| rx_push | input | 1 | Pulse: character entered receive FIFO |
| rx_avail | input | 1 | Receive FIFO holds at least one character |
| rx_special | input | 1 | Character at FIFO head carries a special condition |
| ext_in | input | EXT_W | Live modem and status lines |
| int_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| abort_send | output | 1 | Pulse: send abort sequence and empty transmit buffer |
| err_clr | output | 1 | Pulse: clear receive error bits |
| rx_hold | output | 1 | Hold the FIFO on the special-condition character |
| rx_discard | output | 1 | Pulse: drop the held head character |
| pending | output | 3 | Pending flags {rx, tx, ext} |
| in_service | output | 3 | In-service bits {rx, tx, ext} |
| ext_latched | output | EXT_W | Latched external/status value |

## Verification
Commands and status events often meet on the same clock edge, and the bench pairs them deliberately. It places a tx_buf_empty rise on the edge that carries the transmit-quiet command. It also places an ext_in change on the edge that carries the latch-release command. In both cases it expects the pending flag to survive. The bench also issues an acknowledge and a reset-in-service command back to back while two sources are in service, to confirm that only the top bit retires.

// File: rtl/sio_cmd_pkg.sv
package sio_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NULL     = 3'b000,
    CMD_SPARE    = 3'b001,
    CMD_EXT_REL  = 3'b010,
    CMD_ABORT    = 3'b011,
    CMD_RX_ARM   = 3'b100,
    CMD_TX_QUIET = 3'b101,
    CMD_ERR_CLR  = 3'b110,
    CMD_IUS_RET  = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    RXM_OFF   = 2'b00,
    RXM_FIRST = 2'b01,
    RXM_EVERY = 2'b10,
    RXM_SPEC  = 2'b11
  } rx_mode_e;

  localparam int unsigned NSRC    = 3;
  localparam int unsigned SRC_EXT = 0;
  localparam int unsigned SRC_TX  = 1;
  localparam int unsigned SRC_RX  = 2;

  typedef struct packed {
    logic ext_rel;
    logic abort;
    logic rx_arm;
    logic tx_quiet;
    logic err_clr;
    logic ius_ret;
  } cmd_stb_t;

endpackage

// File: rtl/sio_cmd_dec.sv
module sio_cmd_dec
  import sio_cmd_pkg::*;
(
  input  logic       wr_en,
  input  logic [2:0] cmd_field,
  output cmd_stb_t   stb
);

  cmd_e code;

  always_comb begin
    code = cmd_e'(cmd_field);
    stb  = '0;
    if (wr_en) begin
      unique case (code)
        CMD_EXT_REL:  stb.ext_rel  = 1'b1;
        CMD_ABORT:    stb.abort    = 1'b1;
        CMD_RX_ARM:   stb.rx_arm   = 1'b1;
        CMD_TX_QUIET: stb.tx_quiet = 1'b1;
        CMD_ERR_CLR:  stb.err_clr  = 1'b1;
        CMD_IUS_RET:  stb.ius_ret  = 1'b1;
        default:      stb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/sio_ext_latch.sv
module sio_ext_latch #(
  parameter int unsigned EXT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_W-1:0] ext_in,
  input  logic             ext_ie,
  input  logic             release_cmd,
  output logic             held,
  output logic [EXT_W-1:0] latched
);

  logic [EXT_W-1:0] lat_q, lat_d;
  logic             held_q, held_d;
  logic             fire;
  logic             lat_en;

  // a change is seen only while released; capture freezes the value
  always_comb begin
    fire   = ~held_q & ext_ie & (ext_in != lat_q);
    lat_en = ~held_q;
    lat_d  = ext_in;
    if (fire)
      held_d = 1'b1;
    else if (release_cmd)
      held_d = 1'b0;
    else
      held_d = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      held_q <= held_d;
    end
  end

  assign held    = held_q;
  assign latched = lat_q;

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic            ack,
  input  logic            ius_ret,
  output logic            irq,
  output logic [NSRC-1:0] grant,
  output logic [NSRC-1:0] ius
);

  logic [NSRC-1:0] ius_q, ius_d;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] top_req;
  logic [NSRC-1:0] top_ius;

  // a source requests only when nothing at or above its rank is in service
  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign req[i] = pend[i] & en[i] & ~(|ius_q[NSRC-1:i]);
  end

  always_comb begin
    top_req = '0;
    top_ius = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) begin
        top_req    = '0;
        top_req[i] = 1'b1;
      end
      if (ius_q[i]) begin
        top_ius    = '0;
        top_ius[i] = 1'b1;
      end
    end
    grant = ack ? top_req : '0;
    ius_d = (ius_q & ~(ius_ret ? top_ius : '0)) | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ius_q <= '0;
    else        ius_q <= ius_d;
  end

  assign irq = |req;
  assign ius = ius_q;

endmodule

// File: rtl/sio_cmd_irq.sv
module sio_cmd_irq
  import sio_cmd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CMD_LSB = 3,
  parameter int unsigned EXT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_ie,
  input  logic [1:0]        rx_mode,
  input  logic              ext_ie,
  input  logic              tx_buf_empty,
  input  logic              tx_load,
  input  logic              crc_done,
  input  logic              rx_push,
  input  logic              rx_avail,
  input  logic              rx_special,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic              int_ack,
  output logic              irq,
  output logic              abort_send,
  output logic              err_clr,
  output logic              rx_hold,
  output logic              rx_discard,
  output logic [NSRC-1:0]   pending,
  output logic [NSRC-1:0]   in_service,
  output logic [EXT_W-1:0]  ext_latched
);

  localparam int unsigned CMD_MSB = CMD_LSB + 2;

  cmd_stb_t        stb;
  rx_mode_e        mode;
  logic            unused_bits;
  logic            ext_held;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] en_vec;

  logic txe_q, tx_block_q, tx_pend_q, spec_q, arm_q, rx_pend_q, hold_q;
  logic abort_q, errclr_q, disc_q;
  logic tx_block_d, tx_pend_d, arm_d, rx_pend_d, hold_d;
  logic abort_d, errclr_d, disc_d;
  logic tx_rise, tx_free, tx_set;
  logic spec_now, spec_rise, first_fire, rx_set, hold_mode;

  assign unused_bits = ^wr_data;

  sio_cmd_dec u_dec (
    .wr_en     (wr_en),
    .cmd_field (wr_data[CMD_MSB:CMD_LSB]),
    .stb       (stb)
  );

  sio_ext_latch #(.EXT_W(EXT_W)) u_ext (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_in      (ext_in),
    .ext_ie      (ext_ie),
    .release_cmd (stb.ext_rel),
    .held        (ext_held),
    .latched     (ext_latched)
  );

  // ---------------- transmit and receive pending ----------------
  always_comb begin
    mode = rx_mode_e'(rx_mode);

    tx_rise    = tx_buf_empty & ~txe_q;
    tx_free    = tx_load | crc_done;
    tx_set     = tx_ie & tx_rise & (~tx_block_q | tx_free);
    tx_pend_d  = tx_set | (tx_pend_q & ~(stb.tx_quiet | tx_load));
    tx_block_d = tx_free ? 1'b0 : (stb.tx_quiet | tx_block_q);

    spec_now   = rx_avail & rx_special;
    spec_rise  = spec_now & ~spec_q;
    first_fire = (mode == RXM_FIRST) & arm_q & (rx_push | rx_avail);
    rx_set     = ((mode != RXM_OFF) & spec_rise)
               | ((mode == RXM_EVERY) & rx_push)
               | first_fire;
    rx_pend_d  = rx_set | (rx_pend_q & ~grant[SRC_RX]);
    arm_d      = first_fire ? 1'b0 : (stb.rx_arm | arm_q);

    hold_mode  = (mode == RXM_FIRST) | (mode == RXM_SPEC);
    hold_d     = (hold_mode & spec_rise) | (hold_q & ~stb.err_clr);
    disc_d     = stb.err_clr & hold_q & spec_now;
    errclr_d   = stb.err_clr;
    abort_d    = stb.abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q      <= 1'b1;
      tx_block_q <= 1'b0;
      tx_pend_q  <= 1'b0;
      spec_q     <= 1'b0;
      arm_q      <= 1'b1;
      rx_pend_q  <= 1'b0;
      hold_q     <= 1'b0;
      abort_q    <= 1'b0;
      errclr_q   <= 1'b0;
      disc_q     <= 1'b0;
    end else begin
      txe_q      <= tx_buf_empty;
      tx_block_q <= tx_block_d;
      tx_pend_q  <= tx_pend_d;
      spec_q     <= spec_now;
      arm_q      <= arm_d;
      rx_pend_q  <= rx_pend_d;
      hold_q     <= hold_d;
      abort_q    <= abort_d;
      errclr_q   <= errclr_d;
      disc_q     <= disc_d;
    end
  end

  // ---------------- priority and service ----------------
  assign pending = {rx_pend_q, tx_pend_q, ext_held};
  assign en_vec  = {(mode != RXM_OFF), tx_ie, ext_ie};

  sio_irq_prio u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pending),
    .en      (en_vec),
    .ack     (int_ack),
    .ius_ret (stb.ius_ret),
    .irq     (irq),
    .grant   (grant),
    .ius     (in_service)
  );

  assign abort_send = abort_q;
  assign err_clr    = errclr_q;
  assign rx_hold    = hold_q;
  assign rx_discard = disc_q;

endmodule

// File: rtl/sio_cmd_irq_chk.sv
module sio_cmd_irq_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CMD_LSB = 3,
  parameter int unsigned EXT_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              tx_load,
  input logic              crc_done,
  input logic              int_ack,
  input logic              irq,
  input logic              abort_send,
  input logic              err_clr,
  input logic              rx_hold,
  input logic              rx_discard,
  input logic [2:0]        pending,
  input logic [2:0]        in_service,
  input logic [EXT_W-1:0]  ext_latched,
  input logic              tx_block,
  input logic              ext_held
);

  logic [2:0] code;
  assign code = wr_data[CMD_LSB +: 3];

  p_abort_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code == 3'b011) |=> abort_send);

  p_tx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_block && !tx_load && !crc_done) |=> !$rose(pending[1]));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code == 3'b110) |=> err_clr);

  p_discard_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_discard |-> $past(rx_hold));

  p_ext_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_held |=> $stable(ext_latched));

  p_ack_service_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq) |=> (in_service != 3'b000));

  p_retire_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code == 3'b111 && !int_ack && in_service != 3'b000)
      |=> ($countones(in_service) + 1 == $countones($past(in_service))));

endmodule

bind sio_cmd_irq sio_cmd_irq_chk #(
  .DATA_W (DATA_W),
  .CMD_LSB(CMD_LSB),
  .EXT_W  (EXT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tx_load    (tx_load),
  .crc_done   (crc_done),
  .int_ack    (int_ack),
  .irq        (irq),
  .abort_send (abort_send),
  .err_clr    (err_clr),
  .rx_hold    (rx_hold),
  .rx_discard (rx_discard),
  .pending    (pending),
  .in_service (in_service),
  .ext_latched(ext_latched),
  .tx_block   (tx_block_q),
  .ext_held   (ext_held)
);

// File: tb/tb_sio_cmd_irq.sv
`timescale 1ns/1ps
module tb_sio_cmd_irq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, tx_ie, ext_ie, tx_buf_empty, tx_load, crc_done;
  logic       rx_push, rx_avail, rx_special, int_ack;
  logic [7:0] wr_data;
  logic [1:0] rx_mode, ext_in;
  logic       irq, abort_send, err_clr, rx_hold, rx_discard;
  logic [2:0] pending, in_service;
  logic [1:0] ext_latched;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sio_cmd_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_ie(tx_ie), .rx_mode(rx_mode), .ext_ie(ext_ie),
    .tx_buf_empty(tx_buf_empty), .tx_load(tx_load), .crc_done(crc_done),
    .rx_push(rx_push), .rx_avail(rx_avail), .rx_special(rx_special),
    .ext_in(ext_in), .int_ack(int_ack), .irq(irq), .abort_send(abort_send),
    .err_clr(err_clr), .rx_hold(rx_hold), .rx_discard(rx_discard),
    .pending(pending), .in_service(in_service), .ext_latched(ext_latched)
  );

  // row: wr, data, txe, txl, crc, ext, ack | pend, ius, irq, abort, lat
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0,8'h00,1'b0,1'b0,1'b0,2'b00,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b00,1'b0, 3'b010,3'b000,1'b1,1'b0,2'b00},
    {1'b1,8'h28,1'b1,1'b0,1'b0,2'b00,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b0,1'b0,1'b0,2'b00,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b00,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b0,1'b0,1'b1,2'b00,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b00,1'b0, 3'b010,3'b000,1'b1,1'b0,2'b00},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b00,1'b1, 3'b010,3'b010,1'b0,1'b0,2'b00},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b01,1'b0, 3'b011,3'b010,1'b0,1'b0,2'b01},
    {1'b1,8'h38,1'b1,1'b0,1'b0,2'b01,1'b0, 3'b011,3'b000,1'b1,1'b0,2'b01},
    {1'b0,8'h00,1'b1,1'b1,1'b0,2'b01,1'b0, 3'b001,3'b000,1'b1,1'b0,2'b01},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b01,1'b1, 3'b001,3'b001,1'b0,1'b0,2'b01},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b001,3'b001,1'b0,1'b0,2'b01},
    {1'b1,8'h10,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b001,1'b0,1'b0,2'b01},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b001,3'b001,1'b0,1'b0,2'b11},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b10,1'b0, 3'b001,3'b001,1'b0,1'b0,2'b11},
    {1'b1,8'h10,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b001,1'b0,1'b0,2'b11},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b001,1'b0,1'b0,2'b11},
    {1'b1,8'h38,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b11},
    {1'b1,8'h18,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b000,1'b0,1'b1,2'b11},
    {1'b0,8'h00,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b11},
    {1'b0,8'h00,1'b0,1'b0,1'b0,2'b11,1'b0, 3'b000,3'b000,1'b0,1'b0,2'b11},
    {1'b1,8'h28,1'b1,1'b0,1'b0,2'b11,1'b0, 3'b010,3'b000,1'b1,1'b0,2'b11},
    {1'b1,8'h10,1'b1,1'b0,1'b0,2'b01,1'b0, 3'b011,3'b000,1'b1,1'b0,2'b01},
    {1'b1,8'hC7,1'b1,1'b0,1'b0,2'b01,1'b0, 3'b011,3'b000,1'b1,1'b0,2'b01},
    {1'b1,8'hCF,1'b1,1'b0,1'b0,2'b01,1'b0, 3'b011,3'b000,1'b1,1'b0,2'b01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c);
    wr_en = 1'b1;
    wr_data = {2'b00, c, 3'b000};
    step();
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 0; wr_data = 0; tx_ie = 0; ext_ie = 0; rx_mode = 2'b00;
    tx_buf_empty = 0; tx_load = 0; crc_done = 0; rx_push = 0;
    rx_avail = 0; rx_special = 0; ext_in = 0; int_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 pending", pending, 0);
    check("R1 in_service", in_service, 0);
    check("R1 pulses", {abort_send, err_clr, rx_hold, rx_discard}, 0);
    check("R1 ext_latched", ext_latched, 0);

    // table walk: R2 R3 R4 R8 R9 R10 R11 R12
    tx_ie = 1; ext_ie = 1; rx_mode = 2'b00;
    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][24]; wr_data = VEC[i][23:16];
      tx_buf_empty = VEC[i][15]; tx_load = VEC[i][14]; crc_done = VEC[i][13];
      ext_in = VEC[i][12:11]; int_ack = VEC[i][10];
      step();
      check($sformatf("R4 R8 R12 row %0d pending", i), pending, VEC[i][9:7]);
      check($sformatf("R10 R11 row %0d in_service", i), in_service, VEC[i][6:4]);
      check($sformatf("R9 row %0d irq", i), irq, VEC[i][3]);
      check($sformatf("R3 R2 row %0d abort_send", i), abort_send, VEC[i][2]);
      check($sformatf("R8 row %0d ext_latched", i), ext_latched, VEC[i][1:0]);
    end
    wr_en = 0; tx_load = 0; crc_done = 0; int_ack = 0;

    // R5 first-character mode
    do_reset();
    rx_mode = 2'b01;
    rx_push = 1; rx_avail = 1;
    step();
    rx_push = 0;
    check("R5 first char pending", pending, 3'b100);
    check("R5 first char irq", irq, 1);
    int_ack = 1; step(); int_ack = 0;
    check("R10 ack clears rx pending", pending, 3'b000);
    check("R10 ack sets rx service", in_service, 3'b100);
    rx_push = 1; step(); rx_push = 0;
    check("R5 disarmed ignores char", pending, 3'b000);
    cmd(3'b100);
    check("R5 rearm edge no pending yet", pending, 3'b000);
    step();
    check("R5 stored char after rearm", pending, 3'b100);
    cmd(3'b111);
    check("R11 retire rx", in_service, 3'b000);
    check("R9 irq after retire", irq, 1);

    // R6 every-character and off modes
    int_ack = 1; step(); int_ack = 0; cmd(3'b111);
    rx_avail = 0; rx_mode = 2'b10;
    rx_push = 1; step(); rx_push = 0;
    check("R6 every char first", pending, 3'b100);
    int_ack = 1; step(); int_ack = 0; cmd(3'b111);
    rx_push = 1; step(); rx_push = 0;
    check("R6 every char second", pending, 3'b100);
    int_ack = 1; step(); int_ack = 0; cmd(3'b111);
    rx_mode = 2'b00;
    rx_push = 1; step(); rx_push = 0;
    check("R6 off mode ignores", pending, 3'b000);

    // R7 special condition hold and release
    rx_mode = 2'b11; rx_avail = 1; rx_special = 1;
    step();
    check("R7 hold raised", rx_hold, 1);
    check("R7 special pending", pending, 3'b100);
    cmd(3'b110);
    check("R7 err_clr pulse", err_clr, 1);
    check("R7 discard while unread", rx_discard, 1);
    check("R7 hold dropped", rx_hold, 0);
    step();
    check("R7 pulses one cycle", {err_clr, rx_discard}, 2'b00);
    rx_special = 0; step();
    rx_special = 1; step();
    check("R7 hold again", rx_hold, 1);
    rx_special = 0; step();
    cmd(3'b110);
    check("R7 err_clr after read", err_clr, 1);
    check("R7 no discard after read", rx_discard, 0);
    rx_mode = 2'b10; step();
    rx_special = 1; step();
    check("R7 no hold in every-char mode", rx_hold, 0);
    rx_special = 0; rx_avail = 0;

    // R9 R10 R11 priority and nesting
    do_reset();
    rx_mode = 2'b01; tx_ie = 1;
    step();
    tx_buf_empty = 1; rx_push = 1; rx_avail = 1;
    step();
    rx_push = 0;
    check("R9 both pending", pending, 3'b110);
    int_ack = 1; step(); int_ack = 0;
    check("R10 rx wins ack", in_service, 3'b100);
    check("R9 tx masked by rx service", irq, 0);
    int_ack = 1; step(); int_ack = 0;
    check("R10 ack ignored when irq low", in_service, 3'b100);
    cmd(3'b111);
    check("R9 tx requests after retire", irq, 1);
    int_ack = 1; step(); int_ack = 0;
    check("R10 tx service, pending kept", {in_service, pending}, {3'b010, 3'b010});
    rx_mode = 2'b10; rx_avail = 0;
    rx_push = 1; step(); rx_push = 0;
    check("R9 rx outranks tx service", irq, 1);
    int_ack = 1; step(); int_ack = 0;
    check("R10 nested service", in_service, 3'b110);
    cmd(3'b111);
    check("R11 only top bit retired", in_service, 3'b010);

    finish_run();
  end

endmodule